// File: doc/BRIEF.md
# Read-Strobe Delay Tap Trainer

This block trains the read-strobe delay of a DRAM data path after the memory controller has been configured. On a start pulse it walks a delay tap upward from zero. For each tap value it loads the tap into the lane delay registers and asks an external memory test unit for one test run. The test unit answers with a completion strobe and a count of failed comparisons. A tap passes when that count is zero.

The trainer looks for the first unbroken run of passing taps. A failing tap seen before any pass is skipped. The first failing tap after a pass closes the run and stops the sweep. The trainer then programs the rounded-up midpoint of the run into the lane registers. If no tap passes, it programs a fixed fallback tap. A test run that never completes counts as a failing tap, so one stuck test cannot hang the sweep.

The trainer serves four byte lanes; the upper two lanes are used only on a 32-bit bus. A build option selects a split delay-chain layout, in which large taps are stored as two fields.

Top module: `dqs_tap_trainer`

## Requirements
- R1: After a synchronous active-low reset:
  - `done_o`, `found_o`, `test_start_o` are 0.
  - `result_tap_o` is 0.
  - All lane fields are 0.
  - `test_loops_o` is 8, the loop count the test unit must run per tap.
- R2: The sweep tests taps in ascending order starting at 0, one test run per tap. Failing taps before the first pass do not end the sweep.
- R3: The first passing tap sets the low bound, and each later passing tap raises the high bound. With a low bound L and a high bound H, the result is (L + H + 1) / 2, rounded down.
- R4: The first failing tap after at least one pass makes the high bound that tap minus one and ends the sweep at once. No further test run is started, and a second passing run higher up is ignored.
- R5: If no tap passes:
  - the result is tap 8;
  - `found_o` is 0 while `done_o` is high.
- R6: `done_o` is high for exactly one cycle per training run. In that cycle the following are already final:
  - `found_o`, which is 1 when a pass window was found;
  - `result_tap_o`;
  - the lane fields.
- R7: For every tap, the lane fields are written first. In the cycle after that, `test_start_o` rises and stays high until `test_done_i` is seen, then falls. The failure count is sampled together with `test_done_i`.
- R8: Lane k occupies `lane_tap_o[k*10 +: 10]`.
  - Lanes 0 and 1 are written for every tap and for the result.
  - Lanes 2 and 3 are written only when `width32_i` = 1. With `width32_i` = 0 they keep their previous value.
- R9: In the default single-chain layout, the sweep covers taps 0..63 inclusive and a lane field holds the tap value itself. In the split-chain layout (`SPLIT_CHAIN` = 1), the sweep covers taps 0..62:
  - A tap t ≤ 31 is stored as t.
  - A tap t > 31 is stored with (t − 31) in field bits [9:5] and t[4:0] in bits [4:0].
- R10: If `test_done_i` does not arrive within `TEST_TIMEOUT` cycles of `test_start_o` rising, that tap counts as failing and the sweep continues.
- R11: A pass window that reaches the top tap ends the sweep after the top tap, with the high bound equal to the top tap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Starts a training run when idle |
| width32_i | input | 1 | 1 = 32-bit bus (four lanes), 0 = 16-bit bus (two lanes) |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| found_o | output | 1 | A pass window was found in the last run |
| result_tap_o | output | TAP_W | Trained tap value (raw, not encoded) |
| lane_tap_o | output | 4*ENC_W | Encoded delay field for each of four lanes |
| test_start_o | output | 1 | Request to the test unit, held until it completes |
| test_loops_o | output | LOOP_W | Loops the test unit runs per tap |
| test_done_i | input | 1 | Test unit finished |
| test_fail_cnt_i | input | FAIL_W | Failed comparisons of the finished test |

## Verification
A wrong bound register or a skipped pass/fail decision shows at the ports as a wrong `result_tap_o` and wrong lane fields in the `done_o` cycle. It also shows as a wrong number of `test_start_o` rises, since the sweep ends one tap after the window closes. A broken width gate corrupts lanes 2 and 3 during the sweep, already on the first tap written. A lost timeout leaves `test_start_o` high forever, so `done_o` never arrives.

// File: rtl/dqs_tap_pkg.sv
// Package: shared state type and fixed constants of the tap trainer.
// Assumes: lane count is a fixed property of the data path (four byte lanes).
package dqs_tap_pkg;
    localparam int LANES       = 4;
    localparam int DEFAULT_TAP = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SET,
        ST_LAUNCH,
        ST_RUN,
        ST_FIN,
        ST_DONE
    } trn_state_t;
endpackage

// File: rtl/dqs_tap_encoder.sv
// Module: maps a raw tap to the lane register layout.
// Assumes: in split-chain mode the tap never exceeds 2**TAP_W - 2.
module dqs_tap_encoder #(
    parameter int TAP_W       = 6,
    parameter bit SPLIT_CHAIN = 1'b0,
    localparam int LOW_W      = TAP_W - 1,
    localparam int ENC_W      = 2 * LOW_W
) (
    input  logic [TAP_W-1:0] tap_i,
    output logic [ENC_W-1:0] enc_o
);
    localparam int TOP  = SPLIT_CHAIN ? (2**TAP_W) - 2 : (2**TAP_W) - 1;
    localparam int HALF = TOP / 2;

    generate
        if (SPLIT_CHAIN) begin : g_split
            logic [TAP_W-1:0] upper;
            // upper chain takes the part of the tap above half range
            always_comb begin
                upper = tap_i - TAP_W'(HALF);
                if (int'(tap_i) > HALF)
                    enc_o = {upper[LOW_W-1:0], tap_i[LOW_W-1:0]};
                else
                    enc_o = ENC_W'(tap_i);
            end
        end else begin : g_single
            // single chain stores the tap value directly
            always_comb enc_o = ENC_W'(tap_i);
        end
    endgenerate
endmodule

// File: rtl/dqs_test_port.sv
// Module: runs one memory test per request and reports pass/fail.
// Assumes: test_done_i is meaningful only while the request is held;
// a test that stays silent for TEST_TIMEOUT cycles is reported as failing.
module dqs_test_port #(
    parameter int FAIL_W       = 8,
    parameter int TEST_TIMEOUT = 32,
    localparam int CNT_W       = $clog2(TEST_TIMEOUT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic              test_done_i,
    input  logic [FAIL_W-1:0] test_fail_cnt_i,
    output logic              test_start_o,
    output logic              res_valid_o,
    output logic              res_pass_o
);
    logic             busy;
    logic [CNT_W-1:0] wait_cnt;

    // request hold, timeout count and result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy        <= 1'b0;
            wait_cnt    <= '0;
            res_valid_o <= 1'b0;
            res_pass_o  <= 1'b0;
        end else begin
            res_valid_o <= 1'b0;
            if (go_i && !busy) begin
                busy     <= 1'b1;
                wait_cnt <= '0;
            end else if (busy) begin
                if (test_done_i) begin
                    busy        <= 1'b0;
                    res_valid_o <= 1'b1;
                    res_pass_o  <= (test_fail_cnt_i == '0);
                end else if (wait_cnt == CNT_W'(TEST_TIMEOUT - 1)) begin
                    busy        <= 1'b0;
                    res_valid_o <= 1'b1;
                    res_pass_o  <= 1'b0;
                end else begin
                    wait_cnt <= wait_cnt + 1'b1;
                end
            end
        end
    end

    assign test_start_o = busy;
endmodule

// File: rtl/dqs_lane_regs.sv
// Module: holds the encoded delay field of every byte lane.
// Assumes: lanes 0 and 1 always exist; upper lanes follow the bus width.
module dqs_lane_regs #(
    parameter int ENC_W = 10,
    parameter int LANES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we_i,
    input  logic                   width32_i,
    input  logic [ENC_W-1:0]       data_i,
    output logic [LANES*ENC_W-1:0] lanes_o
);
    generate
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            localparam bit UPPER = (k >= 2);
            logic [ENC_W-1:0] field;
            // per-lane load, gated by bus width for upper lanes
            always_ff @(posedge clk) begin
                if (!rst_n)
                    field <= '0;
                else if (we_i && (!UPPER || width32_i))
                    field <= data_i;
            end
            assign lanes_o[k*ENC_W +: ENC_W] = field;
        end
    endgenerate
endmodule

// File: rtl/dqs_tap_trainer.sv
// Module: top of the read-strobe tap trainer. Sweeps the tap upward,
// finds the first pass window, and programs its rounded-up midpoint.
// Assumes: width32_i is held steady for the duration of a run.
module dqs_tap_trainer #(
    parameter int TAP_W        = 6,
    parameter bit SPLIT_CHAIN  = 1'b0,
    parameter int FAIL_W       = 8,
    parameter int LOOP_W       = 8,
    parameter int TEST_LOOPS   = 8,
    parameter int TEST_TIMEOUT = 32,
    localparam int ENC_W       = 2 * (TAP_W - 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic                    width32_i,
    output logic                    done_o,
    output logic                    found_o,
    output logic [TAP_W-1:0]        result_tap_o,
    output logic [4*ENC_W-1:0]      lane_tap_o,
    output logic                    test_start_o,
    output logic [LOOP_W-1:0]       test_loops_o,
    input  logic                    test_done_i,
    input  logic [FAIL_W-1:0]       test_fail_cnt_i
);
    import dqs_tap_pkg::*;

    localparam int TOP = SPLIT_CHAIN ? (2**TAP_W) - 2 : (2**TAP_W) - 1;

    trn_state_t       state;
    logic [TAP_W-1:0] tap, lo_b, hi_b, final_tap, wr_tap;
    logic [TAP_W:0]   mid_sum;
    logic             got_lo, res_valid, res_pass, go, lane_we;
    logic [ENC_W-1:0] enc;

    // rounded-up midpoint, or the fallback tap when nothing passed
    always_comb begin
        mid_sum   = {1'b0, hi_b} + {1'b0, lo_b} + 1'b1;
        final_tap = got_lo ? mid_sum[TAP_W:1] : TAP_W'(DEFAULT_TAP);
        wr_tap    = (state == ST_FIN) ? final_tap : tap;
        lane_we   = (state == ST_SET) || (state == ST_FIN);
        go        = (state == ST_LAUNCH);
    end

    // sweep sequencer and window bounds
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            tap          <= '0;
            lo_b         <= '0;
            hi_b         <= '0;
            got_lo       <= 1'b0;
            found_o      <= 1'b0;
            result_tap_o <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start_i) begin
                    tap    <= '0;
                    lo_b   <= '0;
                    hi_b   <= '0;
                    got_lo <= 1'b0;
                    state  <= ST_SET;
                end
                ST_SET:    state <= ST_LAUNCH;
                ST_LAUNCH: state <= ST_RUN;
                ST_RUN: if (res_valid) begin
                    if (res_pass) begin
                        if (!got_lo) begin
                            lo_b   <= tap;
                            got_lo <= 1'b1;
                        end
                        hi_b <= tap;
                        if (int'(tap) == TOP) state <= ST_FIN;
                        else begin
                            tap   <= tap + 1'b1;
                            state <= ST_SET;
                        end
                    end else if (got_lo) begin
                        hi_b  <= tap - 1'b1;
                        state <= ST_FIN;
                    end else if (int'(tap) == TOP) begin
                        state <= ST_FIN;
                    end else begin
                        tap   <= tap + 1'b1;
                        state <= ST_SET;
                    end
                end
                ST_FIN: begin
                    result_tap_o <= final_tap;
                    found_o      <= got_lo;
                    state        <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign done_o       = (state == ST_DONE);
    assign test_loops_o = LOOP_W'(TEST_LOOPS);

    dqs_tap_encoder #(.TAP_W(TAP_W), .SPLIT_CHAIN(SPLIT_CHAIN)) enc_i (
        .tap_i(wr_tap), .enc_o(enc)
    );

    dqs_test_port #(.FAIL_W(FAIL_W), .TEST_TIMEOUT(TEST_TIMEOUT)) port_i (
        .clk(clk), .rst_n(rst_n), .go_i(go), .test_done_i(test_done_i),
        .test_fail_cnt_i(test_fail_cnt_i), .test_start_o(test_start_o),
        .res_valid_o(res_valid), .res_pass_o(res_pass)
    );

    dqs_lane_regs #(.ENC_W(ENC_W), .LANES(LANES)) lanes_i (
        .clk(clk), .rst_n(rst_n), .we_i(lane_we), .width32_i(width32_i),
        .data_i(enc), .lanes_o(lane_tap_o)
    );
endmodule

// File: rtl/dqs_tap_trainer_chk.sv
// Module: port-level properties of the tap trainer, bound to every instance.
// Assumes: reset is synchronous and active low.
module dqs_tap_trainer_chk #(
    parameter int TAP_W       = 6,
    parameter bit SPLIT_CHAIN = 1'b0,
    parameter int ENC_W       = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               width32_i,
    input logic               done_o,
    input logic               found_o,
    input logic [TAP_W-1:0]   result_tap_o,
    input logic [4*ENC_W-1:0] lane_tap_o,
    input logic               test_start_o
);
    localparam int TOP = SPLIT_CHAIN ? (2**TAP_W) - 2 : (2**TAP_W) - 1;

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    done_idle_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !test_start_o);

    // R5
    fallback_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !found_o) |-> (result_tap_o == TAP_W'(8)));

    // R11
    result_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (int'(result_tap_o) <= TOP));

    // R8
    upper_lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!width32_i && $past(!width32_i) && $past(rst_n))
        |-> $stable(lane_tap_o[4*ENC_W-1:2*ENC_W]));

    // R8
    upper_lane_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && width32_i)
        |-> (lane_tap_o[2*ENC_W +: ENC_W] == lane_tap_o[0 +: ENC_W]));
endmodule

bind dqs_tap_trainer dqs_tap_trainer_chk #(
    .TAP_W(TAP_W), .SPLIT_CHAIN(SPLIT_CHAIN), .ENC_W(ENC_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .width32_i(width32_i), .done_o(done_o),
    .found_o(found_o), .result_tap_o(result_tap_o),
    .lane_tap_o(lane_tap_o), .test_start_o(test_start_o)
);

// File: tb/dqs_tap_trainer_tb_top.sv
// Model of the external test unit: passes taps inside one of two windows,
// never answers on the hang tap, and counts test requests.
module dqs_test_model #(
    parameter bit SPLIT = 1'b0
) (
    input  logic       clk,
    input  logic       start,
    input  logic [9:0] lane0,
    input  int         w1lo, w1hi, w2lo, w2hi, hang,
    input  logic       clr_runs,
    output logic       done,
    output logic [7:0] fail_cnt,
    output int         runs
);
    int   tap, cnt;
    logic resp, start_q;

    always_comb begin
        if (SPLIT && lane0[9:5] != 5'd0) tap = int'(lane0[9:5]) + 31;
        else if (SPLIT)                  tap = int'(lane0[4:0]);
        else                             tap = int'(lane0);
    end

    always @(posedge clk) begin
        start_q <= start;
        if (clr_runs) runs <= 0;
        else if (start && !start_q) runs <= runs + 1;
        if (!start) begin
            cnt <= 0; done <= 1'b0; resp <= 1'b0;
        end else if (!resp && tap != hang) begin
            if (cnt == 3) begin
                done     <= 1'b1;
                resp     <= 1'b1;
                fail_cnt <= ((tap >= w1lo && tap <= w1hi) ||
                             (tap >= w2lo && tap <= w2hi)) ? 8'd0 : 8'd5;
            end else cnt <= cnt + 1;
        end else done <= 1'b0;
    end
endmodule

module dqs_tap_trainer_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    int n_chk = 0, n_err = 0;

    // single-chain DUT and its test unit
    logic       start_a = 1'b0, w32_a = 1'b0, done_a, found_a, tstart_a, tdone_a, clr_a = 1'b1;
    logic [5:0] res_a;
    logic [39:0] lanes_a;
    logic [7:0] loops_a, fcnt_a;
    int a_w1lo = 100, a_w1hi = 0, a_w2lo = 100, a_w2hi = 0, a_hang = 127, runs_a;

    dqs_tap_trainer dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_a), .width32_i(w32_a),
        .done_o(done_a), .found_o(found_a), .result_tap_o(res_a),
        .lane_tap_o(lanes_a), .test_start_o(tstart_a), .test_loops_o(loops_a),
        .test_done_i(tdone_a), .test_fail_cnt_i(fcnt_a)
    );
    dqs_test_model #(.SPLIT(1'b0)) mdl_a (
        .clk(clk), .start(tstart_a), .lane0(lanes_a[9:0]), .w1lo(a_w1lo), .w1hi(a_w1hi),
        .w2lo(a_w2lo), .w2hi(a_w2hi), .hang(a_hang), .clr_runs(clr_a),
        .done(tdone_a), .fail_cnt(fcnt_a), .runs(runs_a)
    );

    // split-chain DUT and its test unit
    logic       start_b = 1'b0, done_b, found_b, tstart_b, tdone_b, clr_b = 1'b1;
    logic [5:0] res_b;
    logic [39:0] lanes_b;
    logic [7:0] loops_b, fcnt_b;
    int b_w1lo = 100, b_w1hi = 0, runs_b;

    dqs_tap_trainer #(.SPLIT_CHAIN(1'b1)) dut2_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_b), .width32_i(1'b1),
        .done_o(done_b), .found_o(found_b), .result_tap_o(res_b),
        .lane_tap_o(lanes_b), .test_start_o(tstart_b), .test_loops_o(loops_b),
        .test_done_i(tdone_b), .test_fail_cnt_i(fcnt_b)
    );
    dqs_test_model #(.SPLIT(1'b1)) mdl_b (
        .clk(clk), .start(tstart_b), .lane0(lanes_b[9:0]), .w1lo(b_w1lo), .w1hi(b_w1hi),
        .w2lo(100), .w2hi(0), .hang(127), .clr_runs(clr_b),
        .done(tdone_b), .fail_cnt(fcnt_b), .runs(runs_b)
    );

    // w1lo, w1hi, w2lo, w2hi, hang, width32, exp_found, exp_tap, exp_runs
    localparam int NV = 8;
    localparam int VEC [NV][9] = '{
        '{10, 20, 100, 0, 127, 1, 1, 15, 22},  // R3 plain window
        '{ 0,  0, 100, 0, 127, 0, 1,  0,  2},  // R3 single tap at zero
        '{50, 63, 100, 0, 127, 1, 1, 57, 64},  // R11 window to top
        '{ 5, 10,  20,30, 127, 0, 1,  8, 12},  // R4 second window ignored
        '{100, 0, 100, 0, 127, 1, 0,  8, 64},  // R5 no pass
        '{30, 40, 100, 0,  35, 0, 1, 32, 36},  // R10 hang closes window
        '{63, 63, 100, 0, 127, 1, 1, 63, 64},  // R11 top tap only
        '{ 2,  9, 100, 0,   3, 1, 1,  2,  4}   // R10 hang right after pass
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // waits for a done pulse; returns 0 on watchdog expiry
    task automatic wait_done(input bit which_b, output bit seen);
        seen = 1'b0;
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            if ((which_b ? done_b : done_a) === 1'b1) begin seen = 1'b1; break; end
        end
        if (!seen) check(1'b0, "watchdog", 0, 1);
    endtask

    function automatic int split_enc(input int t);
        return (t > 31) ? (((t - 31) << 5) | (t & 31)) : t;
    endfunction

    initial begin
        bit seen;
        int prev_up;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(done_a == 0 && found_a == 0 && tstart_a == 0, "R1 flags", int'(done_a), 0);
        check(lanes_a == '0 && res_a == '0, "R1 lanes", int'(lanes_a[9:0]), 0);
        check(loops_a == 8, "R1 loop count", int'(loops_a), 8);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            a_w1lo = VEC[v][0]; a_w1hi = VEC[v][1]; a_w2lo = VEC[v][2];
            a_w2hi = VEC[v][3]; a_hang = VEC[v][4]; w32_a = VEC[v][5][0];
            clr_a = 1'b1; @(negedge clk); clr_a = 1'b0;
            prev_up = int'(lanes_a[29:20]);
            start_a = 1'b1; @(negedge clk); start_a = 1'b0;
            wait_done(1'b0, seen);
            if (seen) begin
                check(found_a == VEC[v][6][0], "R5/R6 found flag", int'(found_a), VEC[v][6]);
                check(int'(res_a) == VEC[v][7], "R3 result tap", int'(res_a), VEC[v][7]);
                check(int'(lanes_a[9:0]) == VEC[v][7] && int'(lanes_a[19:10]) == VEC[v][7],
                      "R8 lanes 0/1", int'(lanes_a[19:10]), VEC[v][7]);
                if (VEC[v][5] != 0)
                    check(int'(lanes_a[29:20]) == VEC[v][7] && int'(lanes_a[39:30]) == VEC[v][7],
                          "R8 lanes 2/3 written", int'(lanes_a[39:30]), VEC[v][7]);
                else
                    check(int'(lanes_a[29:20]) == prev_up && int'(lanes_a[39:30]) == prev_up,
                          "R8 lanes 2/3 kept", int'(lanes_a[39:30]), prev_up);
                check(runs_a == VEC[v][8], "R2/R4 test runs", runs_a, VEC[v][8]);
                @(negedge clk);
                check(done_a == 1'b0, "R6 done pulse width", int'(done_a), 0);
            end
        end

        // R7 handshake: lane written before start, start held until done
        a_w1lo = 10; a_w1hi = 20; a_hang = 127; w32_a = 1'b1;
        start_a = 1'b1; @(negedge clk); start_a = 1'b0;
        @(negedge clk);  // SET edge passed: lane holds tap 0
        check(lanes_a[9:0] == 10'd0 && tstart_a == 1'b0, "R7 lane before start", int'(tstart_a), 0);
        @(negedge clk);  // LAUNCH edge passed
        check(tstart_a == 1'b1, "R7 start raised", int'(tstart_a), 1);
        repeat (3) @(negedge clk);
        check(tstart_a == 1'b1, "R7 start held", int'(tstart_a), 1);
        wait_done(1'b0, seen);

        // R1 reset during a sweep returns to the reset state
        start_a = 1'b1; @(negedge clk); start_a = 1'b0;
        repeat (20) @(negedge clk);
        rst_n = 1'b0; @(negedge clk);
        check(tstart_a == 0 && lanes_a == '0 && found_a == 0, "R1 mid-run reset", int'(tstart_a), 0);
        rst_n = 1'b1; @(negedge clk);

        // R9 split-chain layout on the second instance
        begin
            int cases [4][4] = '{'{40, 50, 45, 52}, '{100, 0, 8, 63},
                                 '{60, 62, 61, 63}, '{10, 20, 15, 22}};
            for (int k = 0; k < 4; k++) begin
                b_w1lo = cases[k][0]; b_w1hi = cases[k][1];
                clr_b = 1'b1; @(negedge clk); clr_b = 1'b0;
                start_b = 1'b1; @(negedge clk); start_b = 1'b0;
                wait_done(1'b1, seen);
                if (seen) begin
                    check(int'(res_b) == cases[k][2], "R9 split result", int'(res_b), cases[k][2]);
                    check(int'(lanes_b[9:0]) == split_enc(cases[k][2]) &&
                          int'(lanes_b[39:30]) == split_enc(cases[k][2]),
                          "R9 split encoding", int'(lanes_b[9:0]), split_enc(cases[k][2]));
                    check(runs_b == cases[k][3], "R9 split sweep length", runs_b, cases[k][3]);
                end
            end
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule